// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a three-wire link to a 10-bit sampling converter. A single start pulse makes it lower the converter's select line with the serial clock parked low. It then waits for the converter to finish. In flag mode, the wait ends when the data line rises. In timeout mode, it ends after a fixed number of cycles. Next, the block produces a burst of serial-clock cycles from the system clock and samples the data line on every rising edge. It discards the leading framing bit and returns the 10-bit sample, plus the two sub-bits when a long read is chosen. The select line then rises and stays high for a minimum recovery time before the block accepts the next start.

Clock polarity and phase are both zero: the clock idles low, the converter changes data after a falling edge, and the block samples on the rising edge. A short read produces 11 clock cycles (flag plus ten data bits). A long read produces 16 cycles, which suits a host that moves whole bytes. The two mode inputs are captured with the start request.

The controller moves through four states:
- `ST_IDLE` goes to `ST_CONV` on start.
- `ST_CONV` goes to `ST_SHIFT` when the flag is seen, or on timeout in timeout mode.
- `ST_CONV` goes to `ST_REST` (abort) on timeout in flag mode.
- `ST_SHIFT` goes to `ST_REST` after the last falling edge.
- `ST_REST` goes to `ST_IDLE` once the recovery count ends.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, select is high, serial clock low, and busy, valid, error and the sample output are all zero.
- R2: A start seen in idle lowers select on the next clock edge. The serial clock stays low whenever select is high and during the whole conversion wait.
- R3: In flag mode (wait_flag_i=1), a high level on the data line, passed through a two-flop synchronizer, ends the wait. The first rising serial-clock edge comes HALF_CYC cycles after the wait ends, which is d+3+HALF_CYC cycles after select falls when the data line rises d cycles after select falls.
- R4: In timeout mode (wait_flag_i=0), the data line is ignored during the wait. The first rising edge comes exactly CONV_CYC+HALF_CYC cycles after select falls.
- R5: Each serial-clock phase inside a burst lasts exactly HALF_CYC cycles. A short read (long_read_i=0) makes 11 rising edges and a long read (long_read_i=1) makes 16.
- R6: Bits are captured on rising edges, and the first captured bit is dropped. sample_o takes captured bits 2 to 11, most significant first. In long mode, sub_o takes bits 12 and 13 (bit 12 in sub_o[1]). In short mode, sub_o is 0.
- R7: Select rises on the same edge as the last falling clock edge. valid_o is high for exactly that one cycle, and sample_o changes only in that cycle.
- R8: After a completed read, select stays high for CSH_CYC+1 cycles when start is held high.
- R9: In flag mode, if CONV_CYC cycles pass with no flag, error_o pulses for one cycle and select rises. No clock edge is made, valid_o stays low, and sample_o keeps its old value. Select then stays high for ABORT_CYC+1 cycles when start is held.
- R10: A start request while busy (during a conversion, a burst or the recovery time) is ignored.
- R11: Changes on wait_flag_i and long_read_i after the start has been taken do not affect the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion and read |
| wait_flag_i | input | 1 | 1: end the wait on the data-line flag; 0: wait a fixed time |
| long_read_i | input | 1 | 1: 16-clock read with sub-bits; 0: 11-clock read |
| busy_o | output | 1 | High from start until recovery ends |
| valid_o | output | 1 | One-cycle pulse when sample_o is updated |
| error_o | output | 1 | One-cycle pulse when flag mode times out |
| sample_o | output | 10 | Last converted sample |
| sub_o | output | 2 | Sub-bits of the last long read |
| adc_cs_n_o | output | 1 | Converter select, active low |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_dout_i | input | 1 | Serial data from the converter |

## Verification
Two events can land in the same cycle: the synchronized flag arriving in flag mode, and the conversion timeout ending. The converter model in the bench raises the flag a chosen number of cycles after select falls. The bench checks the exact cycle of the first clock edge for a flag close to the timeout, and also a run with no flag at all, which must abort. The last falling clock edge, the rise of select and the valid pulse share one edge. The bench samples that cycle and checks all three together with the burst length.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_REST  = 2'd3
    } adcrd_state_t;

    localparam int unsigned RES_W      = 10;
    localparam int unsigned SUB_W      = 2;
    localparam int unsigned FRAME_LONG = 16;
endpackage

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
    parameter int unsigned HALF_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          wrap;

    assign wrap = run_i && (cnt_q == CW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (!run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
    assign rise_o = wrap && !sclk_q;
    assign fall_o = wrap && sclk_q;

    // R2: the clock is parked low one edge after the run request drops
    assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sclk_q);
endmodule

// File: rtl/adcrd_shreg.sv
module adcrd_shreg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q_o <= '0;
        else if (clr_i)   q_o <= '0;
        else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
    end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adcrd_pkg::*;
#(
    parameter int unsigned HALF_CYC  = 24,
    parameter int unsigned CONV_CYC  = 750,
    parameter int unsigned CSH_CYC   = 24,
    parameter int unsigned ABORT_CYC = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wait_flag_i,
    input  logic             long_read_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic             error_o,
    output logic [RES_W-1:0] sample_o,
    output logic [SUB_W-1:0] sub_o,
    output logic             adc_cs_n_o,
    output logic             adc_sclk_o,
    input  logic             adc_dout_i
);
    localparam int unsigned FRAME_SHORT = RES_W + 1;
    localparam int unsigned CCW         = $clog2(CONV_CYC + 1);
    localparam int unsigned REST_MAX    = (ABORT_CYC > CSH_CYC) ? ABORT_CYC : CSH_CYC;
    localparam int unsigned RCW         = $clog2(REST_MAX + 1);
    localparam int unsigned BCW         = $clog2(FRAME_LONG + 1);
    localparam int unsigned LONG_MSB    = FRAME_LONG - 2;
    localparam int unsigned LONG_SUBMSB = FRAME_LONG - 2 - RES_W;

    adcrd_state_t state_q, state_d;

    logic                  dout_s;
    logic                  run, rise, fall;
    logic [FRAME_LONG-1:0] frame_q;
    logic                  flag_mode_q, long_q, abort_q;
    logic [CCW-1:0]        wait_cnt_q;
    logic [RCW-1:0]        rest_cnt_q;
    logic [BCW-1:0]        fall_cnt_q;
    logic [BCW-1:0]        last_fall;
    logic                  cs_n_q, valid_q, err_q;
    logic [RES_W-1:0]      sample_q;
    logic [SUB_W-1:0]      sub_q;
    logic                  take_start, wait_over, burst_done, rest_over;

    adcrd_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(adc_dout_i), .q_o(dout_s)
    );

    assign run = (state_q == ST_SHIFT);

    adcrd_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .sclk_o(adc_sclk_o), .rise_o(rise), .fall_o(fall)
    );

    adcrd_shreg #(.W(FRAME_LONG)) u_frame (
        .clk(clk), .rst_n(rst_n), .clr_i(take_start),
        .shift_i(rise), .bit_i(dout_s), .q_o(frame_q)
    );

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign wait_over  = (wait_cnt_q == CCW'(CONV_CYC - 1));
    assign last_fall  = long_q ? BCW'(FRAME_LONG - 1) : BCW'(FRAME_SHORT - 1);
    assign burst_done = fall && (fall_cnt_q == last_fall);
    assign rest_over  = abort_q ? (rest_cnt_q == RCW'(ABORT_CYC - 1))
                                : (rest_cnt_q == RCW'(CSH_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CONV;
            ST_CONV: begin
                if (flag_mode_q && dout_s) state_d = ST_SHIFT;
                else if (wait_over)        state_d = flag_mode_q ? ST_REST : ST_SHIFT;
            end
            ST_SHIFT: if (burst_done) state_d = ST_REST;
            ST_REST:  if (rest_over)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q      <= 1'b1;
            valid_q     <= 1'b0;
            err_q       <= 1'b0;
            flag_mode_q <= 1'b0;
            long_q      <= 1'b0;
            abort_q     <= 1'b0;
            wait_cnt_q  <= '0;
            rest_cnt_q  <= '0;
            fall_cnt_q  <= '0;
            sample_q    <= '0;
            sub_q       <= '0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cs_n_q      <= 1'b0;
                        flag_mode_q <= wait_flag_i;
                        long_q      <= long_read_i;
                        abort_q     <= 1'b0;
                        wait_cnt_q  <= '0;
                        fall_cnt_q  <= '0;
                    end
                end
                ST_CONV: begin
                    wait_cnt_q <= wait_cnt_q + 1'b1;
                    if (!(flag_mode_q && dout_s) && wait_over && flag_mode_q) begin
                        cs_n_q     <= 1'b1;
                        err_q      <= 1'b1;
                        abort_q    <= 1'b1;
                        rest_cnt_q <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (fall) fall_cnt_q <= fall_cnt_q + 1'b1;
                    if (burst_done) begin
                        cs_n_q     <= 1'b1;
                        valid_q    <= 1'b1;
                        rest_cnt_q <= '0;
                        if (long_q) begin
                            sample_q <= frame_q[LONG_MSB -: RES_W];
                            sub_q    <= frame_q[LONG_SUBMSB -: SUB_W];
                        end else begin
                            sample_q <= frame_q[RES_W-1:0];
                            sub_q    <= '0;
                        end
                    end
                end
                ST_REST: rest_cnt_q <= rest_cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign valid_o    = valid_q;
    assign error_o    = err_q;
    assign sample_o   = sample_q;
    assign sub_o      = sub_q;
    assign adc_cs_n_o = cs_n_q;

    assert_sclk_low_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n_o |-> !adc_sclk_o);
    assert_no_clock_in_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV) |-> !adc_sclk_o);
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    assert_valid_at_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $rose(adc_cs_n_o));
    assert_sample_moves_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_q) |-> valid_q);
    assert_error_excludes_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_q && err_q));
    assert_select_only_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n_o) |-> ($past(state_q) == ST_IDLE));
endmodule

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF  = 4;
    localparam int CONV  = 80;
    localparam int CSH   = 6;
    localparam int ABORT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, wait_flag = 1'b0, long_read = 1'b0;
    logic busy, valid, error, cs_n, sclk;
    logic dout;
    logic [9:0] sample;
    logic [1:0] sub;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_reader #(.HALF_CYC(HALF), .CONV_CYC(CONV), .CSH_CYC(CSH), .ABORT_CYC(ABORT))
    u_adc_serial_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .wait_flag_i(wait_flag),
        .long_read_i(long_read), .busy_o(busy), .valid_o(valid), .error_o(error),
        .sample_o(sample), .sub_o(sub), .adc_cs_n_o(cs_n), .adc_sclk_o(sclk),
        .adc_dout_i(dout)
    );

    // converter model and link monitor, sampled away from the active edge
    logic [15:0] m_stream = '0;
    int  m_delay = 0;
    bit  m_eoc = 1'b1;
    int  m_ptr, t, rises, t_first, ph_cnt, ph_min, ph_max, hi_cnt, last_gap, sclk_bad, cs_falls;
    logic prev_sclk, prev_cs;

    always @(negedge clk) begin
        if (!rst_n) begin
            dout = 1'b0; m_ptr = 0; t = 0; rises = 0; t_first = -1; ph_cnt = 0;
            ph_min = 1000000; ph_max = 0; hi_cnt = 0; last_gap = 0; sclk_bad = 0;
            cs_falls = 0; prev_sclk = 1'b0; prev_cs = 1'b1;
        end else begin
            if (prev_cs && !cs_n) begin
                last_gap = hi_cnt; hi_cnt = 0; t = 0; rises = 0; t_first = -1;
                ph_min = 1000000; ph_max = 0; m_ptr = 0; dout = 1'b0; cs_falls++;
            end else if (cs_n) begin
                hi_cnt = (!prev_cs) ? 1 : hi_cnt + 1;
            end else begin
                t++;
            end
            if (sclk != prev_sclk) begin
                if (rises > 0) begin
                    if (ph_cnt < ph_min) ph_min = ph_cnt;
                    if (ph_cnt > ph_max) ph_max = ph_cnt;
                end
                ph_cnt = 1;
                if (sclk) begin
                    if (rises == 0) t_first = t;
                    rises++;
                end else if (!cs_n) begin
                    m_ptr++;
                    dout = (m_ptr < 16) ? m_stream[15 - m_ptr] : 1'b0;
                end
            end else begin
                ph_cnt++;
            end
            if (!cs_n && rises == 0 && t == m_delay && m_eoc) dout = m_stream[15];
            if (!prev_cs && cs_n) dout = 1'b0;
            if (cs_n && sclk) sclk_bad++;
            prev_sclk = sclk;
            prev_cs = cs_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // result of the last transaction
    bit g_valid, g_err, g_cs_at_end, g_sclk_at_end, g_valid_next;
    logic [9:0] g_res;
    logic [1:0] g_sub;
    int g_rises, g_tfirst, g_phmin, g_phmax;

    task automatic finish_txn();
        int n;
        n = 0;
        while (!(valid || error) && n < 5000) begin @(negedge clk); n++; end
        g_valid = valid; g_err = error; g_res = sample; g_sub = sub;
        g_cs_at_end = cs_n; g_sclk_at_end = sclk;
        #1;
        g_rises = rises; g_tfirst = t_first; g_phmin = ph_min; g_phmax = ph_max;
        @(negedge clk);
        g_valid_next = valid;
    endtask

    task automatic setup(input bit flag, input bit lng, input logic [9:0] d,
                         input logic [1:0] s, input int dly, input bit eoc);
        wait_flag = flag; long_read = lng; m_stream = {1'b1, d, s, 3'b000};
        m_delay = dly; m_eoc = eoc;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic run_txn(input bit flag, input bit lng, input logic [9:0] d,
                           input logic [1:0] s, input int dly, input bit eoc);
        @(negedge clk);
        setup(flag, lng, d, s, dly, eoc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_txn();
    endtask

    // {flag mode, long read, flag delay[7:0], data[9:0], sub[1:0]}
    localparam logic [21:0] VECS [8] = '{
        {1'b1, 1'b1, 8'd20, 10'h2AA, 2'b01},
        {1'b1, 1'b0, 8'd5,  10'h155, 2'b11},
        {1'b0, 1'b1, 8'd30, 10'h3FF, 2'b11},
        {1'b0, 1'b0, 8'd70, 10'h000, 2'b00},
        {1'b1, 1'b1, 8'd0,  10'h200, 2'b10},
        {1'b1, 1'b0, 8'd60, 10'h001, 2'b01},
        {1'b0, 1'b1, 8'd1,  10'h0F0, 2'b00},
        {1'b1, 1'b1, 8'd75, 10'h3C3, 2'b11}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int falls0, exp_t;
        logic [9:0] prev_res;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cs_n === 1'b1 && sclk === 1'b0, "R1 select/clock at reset", {cs_n, sclk}, 2);
        check(busy === 1'b0 && valid === 1'b0 && error === 1'b0, "R1 flags at reset",
              {busy, valid, error}, 0);
        check(sample === 10'd0, "R1 sample at reset", sample, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            logic [21:0] v;
            v = VECS[i];
            run_txn(v[21], v[20], v[11:2], v[1:0], int'(v[19:12]), 1'b1);
            check(g_valid && !g_err, "R7 valid pulse", g_valid, 1);
            check(!g_valid_next, "R7 valid one cycle", g_valid_next, 0);
            check(g_cs_at_end && !g_sclk_at_end, "R7 select up at last fall", g_cs_at_end, 1);
            check(g_res == v[11:2], "R6 sample", g_res, v[11:2]);
            check(g_sub == (v[20] ? v[1:0] : 2'b00), "R6 sub bits", g_sub, v[20] ? v[1:0] : 0);
            check(g_rises == (v[20] ? 16 : 11), "R5 edge count", g_rises, v[20] ? 16 : 11);
            check(g_phmin == HALF && g_phmax == HALF, "R5 phase width", g_phmin, HALF);
            exp_t = v[21] ? int'(v[19:12]) + 3 + HALF : CONV + HALF;
            check(g_tfirst == exp_t, v[21] ? "R3 flag start" : "R4 timeout start", g_tfirst, exp_t);
            check(sclk_bad == 0, "R2 clock while deselected", sclk_bad, 0);
            wait_idle();
        end

        // R9: flag never arrives
        prev_res = sample;
        run_txn(1'b1, 1'b1, 10'h111, 2'b01, 0, 1'b0);
        check(g_err && !g_valid, "R9 error pulse", g_err, 1);
        check(g_cs_at_end, "R9 select released", g_cs_at_end, 1);
        check(g_rises == 0, "R9 no clocks", g_rises, 0);
        check(g_res == prev_res, "R9 sample kept", g_res, prev_res);
        // R9: recovery after abort, start held
        setup(1'b1, 1'b0, 10'h0AB, 2'b10, 10, 1'b1);
        start = 1'b1;
        while (!cs_n) @(negedge clk);
        while (cs_n) @(negedge clk);
        start = 1'b0;
        #1;
        check(last_gap == ABORT + 1, "R9 abort recovery", last_gap, ABORT + 1);
        finish_txn();
        check(g_valid && g_res == 10'h0AB, "R9 read after abort", g_res, 10'h0AB);

        // R8: recovery after a normal read, start held
        setup(1'b0, 1'b1, 10'h321, 2'b01, 10, 1'b1);
        start = 1'b1;
        while (!cs_n) @(negedge clk);
        while (cs_n) @(negedge clk);
        start = 1'b0;
        #1;
        check(last_gap == CSH + 1, "R8 select high time", last_gap, CSH + 1);
        finish_txn();
        check(g_res == 10'h321 && g_sub == 2'b01, "R8 read after recovery", g_res, 10'h321);
        wait_idle();

        // R10: start pulses while busy are ignored
        @(negedge clk);
        falls0 = cs_falls;
        setup(1'b1, 1'b0, 10'h2C5, 2'b00, 8, 1'b1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        finish_txn();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3 * ABORT) @(negedge clk);
        #1;
        check(cs_falls - falls0 == 1, "R10 busy start ignored", cs_falls - falls0, 1);
        check(cs_n === 1'b1 && !busy, "R10 idle after ignored start", cs_n, 1);

        // R11: mode inputs changed mid-transaction
        @(negedge clk);
        setup(1'b1, 1'b1, 10'h1E7, 2'b10, 10, 1'b1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_flag = 1'b0;
        long_read = 1'b0;
        finish_txn();
        check(g_rises == 16, "R11 long read kept", g_rises, 16);
        check(g_tfirst == 10 + 3 + HALF, "R11 flag mode kept", g_tfirst, 10 + 3 + HALF);
        check(g_res == 10'h1E7 && g_sub == 2'b10, "R11 data", g_res, 10'h1E7);
        wait_idle();

        summary();
        $finish;
    end
endmodule